// File: doc/BRIEF.md
# Most-Urgent-Cell-First Matcher

This block schedules the crossbar of a small switch that keeps queues at both its inputs and its outputs and runs its fabric at twice the line rate. With that speedup each slot splits into two phases. Each phase moves at most one cell out of every input and at most one cell into every output. The aim is for the switch to send out exactly the cells that an ideal switch with only output queues would send. Every head cell therefore carries an urgency: the number of slots left before that ideal switch would send it. A smaller urgency means the cell is more urgent, and a cell at zero must leave now.

At the start of a phase the queue manager supplies, for every pair of input and output, a flag that says a cell is present and the urgency of that cell, and it pulses `start_i`. The block then runs one request and grant round per clock. In each round, every output that has no match yet asks for its most urgent cell held at an input that is also free. Each input that is asked grants the request whose cell is most urgent. Outputs that lose try again in the next round against the inputs that are still free. When a round adds no match, or after N rounds, the block raises `done_o` and holds the matched pairs for the transfer.

Top module: `mucf_matcher`

## Requirements
- R1: After reset, `done_o`, `phase_o`, every bit of `match_vld_o` and every field of `match_in_o` read 0.
- R2: A `start_i` pulse captures the table on that edge. From the next cycle `done_o` and `match_vld_o` read 0. Changes to the table inputs after that edge have no effect until the next `start_i`.
- R3: The cell for input i and output o has its present flag at bit `i*N+o` of `present_i` and its urgency at bits `(i*N+o)*UW +: UW` of `urgency_i`. A cell whose present flag is clear takes no part, whatever its urgency.
- R4: In a round, each unmatched output requests, among the unmatched inputs that hold a present cell for it, the input whose cell has the smallest urgency. A tie goes to the lower input index.
- R5: An input that receives several requests grants the output whose cell has the smallest urgency. A tie goes to the lower output index.
- R6: An output that loses a round requests again in later rounds, and inputs that are already matched are left out. When `done_o` rises, no unmatched output has a present cell at an unmatched input.
- R7: In each phase, every input is matched to at most one output and every output to at most one input.
- R8: Rounds run one per clock. `done_o` rises on the k-th rising edge after the start edge, where k is one more than the number of rounds that added a match, capped at N.
- R9: While `done_o` is high and no `start_i` arrives, `done_o`, `match_vld_o` and `match_in_o` hold their values.
- R10: `phase_o` is 0 for the first phase after reset and alternates between 0 and 1 on each later `start_i`.
- R11: `match_in_o[o*IW +: IW]` gives the input matched to output o. The field reads 0 when `match_vld_o[o]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a phase and captures the table |
| present_i | input | N*N | Cell-present flags, index i*N+o |
| urgency_i | input | N*N*UW | Urgency of each cell, same order |
| match_vld_o | output | N | Output o has a matched input |
| match_in_o | output | N*IW | Input index matched to each output |
| done_o | output | 1 | The matching for this phase is complete |
| phase_o | output | 1 | Index of the current phase within the slot |

## Verification
A wrong ranking or a wrong tie rule shows up as a different input index in `match_in_o` in the same phase that caused it. Each phase finishes within N+1 cycles, so this is visible at once. A matched-set register that keeps stale bits shows up as an output left unmatched even though it has a present cell. A round counter that is off by one moves the rising edge of `done_o` by a cycle. The stimulus includes urgency ties resolved on both the input side and the output side, an urgent cell that is absent, and a table that changes after the start. Each of these cases drives a different field of the result.

// File: rtl/mucf_pkg.sv
package mucf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mucf_state_e;
endpackage

// File: rtl/mucf_pick.sv
// Argmin over N candidates; strict compare keeps the lowest index on a tie.
module mucf_pick #(
  parameter int N  = 4,
  parameter int UW = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*UW-1:0] urg_i,
  output logic            vld_o,
  output logic [IW-1:0]   idx_o
);
  logic [UW-1:0] best;
  logic          found;
  logic [IW-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int k = 0; k < N; k++) begin
      if (cand_i[k] && (!found || urg_i[k*UW +: UW] < best)) begin
        found = 1'b1;
        idx   = IW'(k);
        best  = urg_i[k*UW +: UW];
      end
    end
  end

  assign vld_o = found;
  assign idx_o = idx;
endmodule

// File: rtl/mucf_round.sv
// One request/grant round over the captured table.
module mucf_round #(
  parameter int N  = 4,
  parameter int UW = 4,
  parameter int IW = 2
) (
  input  logic [N*N-1:0]    pres_i,
  input  logic [N*N*UW-1:0] urg_i,
  input  logic [N-1:0]      in_busy_i,
  input  logic [N-1:0]      out_busy_i,
  output logic [N-1:0]      gnt_vld_o,
  output logic [N*IW-1:0]   gnt_out_o
);
  logic [N-1:0]    req_vld;
  logic [IW-1:0]   req_in   [N];
  logic [N-1:0]    req_cand [N];
  logic [N*UW-1:0] col_urg  [N];
  logic [N-1:0]    gnt_cand [N];

  // request side: one picker per output over its column
  for (genvar o = 0; o < N; o++) begin : g_req
    always_comb begin
      for (int i = 0; i < N; i++) begin
        req_cand[o][i]           = pres_i[i*N+o] && !in_busy_i[i] && !out_busy_i[o];
        col_urg[o][i*UW +: UW]   = urg_i[(i*N+o)*UW +: UW];
      end
    end

    mucf_pick #(.N(N), .UW(UW), .IW(IW)) u_req (
      .cand_i (req_cand[o]),
      .urg_i  (col_urg[o]),
      .vld_o  (req_vld[o]),
      .idx_o  (req_in[o])
    );
  end

  // grant side: one picker per input over its row
  for (genvar i = 0; i < N; i++) begin : g_gnt
    always_comb begin
      for (int o = 0; o < N; o++) begin
        gnt_cand[i][o] = req_vld[o] && (req_in[o] == IW'(i));
      end
    end

    mucf_pick #(.N(N), .UW(UW), .IW(IW)) u_gnt (
      .cand_i (gnt_cand[i]),
      .urg_i  (urg_i[i*N*UW +: N*UW]),
      .vld_o  (gnt_vld_o[i]),
      .idx_o  (gnt_out_o[i*IW +: IW])
    );
  end
endmodule

// File: rtl/mucf_matcher.sv
module mucf_matcher #(
  parameter  int N  = 4,
  parameter  int UW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N*N-1:0]    present_i,
  input  logic [N*N*UW-1:0] urgency_i,
  output logic [N-1:0]      match_vld_o,
  output logic [N*IW-1:0]   match_in_o,
  output logic              done_o,
  output logic              phase_o
);
  import mucf_pkg::*;

  mucf_state_e       state_q;
  logic [N*N-1:0]    pres_q;
  logic [N*N*UW-1:0] urg_q;
  logic [N-1:0]      in_busy_q;
  logic [N-1:0]      out_busy_q;
  logic [N*IW-1:0]   match_in_q;
  logic [CW-1:0]     rnd_q;
  logic              done_q;
  logic              phase_q;
  logic              nxt_phase_q;

  logic [N-1:0]      gnt_vld;
  logic [N*IW-1:0]   gnt_out;
  logic [N-1:0]      out_set;
  logic [N*IW-1:0]   match_in_d;
  logic              last_rnd;

  mucf_round #(.N(N), .UW(UW), .IW(IW)) u_round (
    .pres_i     (pres_q),
    .urg_i      (urg_q),
    .in_busy_i  (in_busy_q),
    .out_busy_i (out_busy_q),
    .gnt_vld_o  (gnt_vld),
    .gnt_out_o  (gnt_out)
  );

  always_comb begin
    out_set    = '0;
    match_in_d = match_in_q;
    for (int i = 0; i < N; i++) begin
      if (gnt_vld[i]) begin
        out_set[gnt_out[i*IW +: IW]]               = 1'b1;
        match_in_d[gnt_out[i*IW +: IW]*IW +: IW]   = IW'(i);
      end
    end
  end

  assign last_rnd = (gnt_vld == '0) || (rnd_q == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pres_q      <= '0;
      urg_q       <= '0;
      in_busy_q   <= '0;
      out_busy_q  <= '0;
      match_in_q  <= '0;
      rnd_q       <= '0;
      done_q      <= 1'b0;
      phase_q     <= 1'b0;
      nxt_phase_q <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_RUN;
      pres_q      <= present_i;
      urg_q       <= urgency_i;
      in_busy_q   <= '0;
      out_busy_q  <= '0;
      match_in_q  <= '0;
      rnd_q       <= '0;
      done_q      <= 1'b0;
      phase_q     <= nxt_phase_q;
      nxt_phase_q <= ~nxt_phase_q;
    end else if (state_q == ST_RUN) begin
      in_busy_q  <= in_busy_q | gnt_vld;
      out_busy_q <= out_busy_q | out_set;
      match_in_q <= match_in_d;
      rnd_q      <= rnd_q + CW'(1);
      if (last_rnd) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign match_vld_o = out_busy_q;
  assign match_in_o  = match_in_q;
  assign done_o      = done_q;
  assign phase_o     = phase_q;
endmodule

// File: rtl/mucf_matcher_chk.sv
module mucf_matcher_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [N-1:0]    match_vld_o,
  input logic [N*IW-1:0] match_in_o,
  input logic            done_o
);
  localparam int LW = $clog2(N + 2) + 1;

  logic          run_q;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      lat_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      lat_q <= '0;
    end else if (run_q && !done_o) begin
      lat_q <= lat_q + LW'(1);
    end else if (done_o) begin
      run_q <= 1'b0;
    end
  end

  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && match_vld_o == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(match_vld_o) && $stable(match_in_o)));

  // R8
  round_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !done_o) |-> (lat_q < LW'(N)));

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0] hit;
    always_comb begin
      for (int o = 0; o < N; o++) begin
        hit[o] = match_vld_o[o] && (match_in_o[o*IW +: IW] == IW'(i));
      end
    end
    // R7
    in_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit) <= 1);
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    // R11
    idle_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !match_vld_o[o] |-> (match_in_o[o*IW +: IW] == '0));
  end
endmodule

bind mucf_matcher mucf_matcher_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .match_vld_o (match_vld_o),
  .match_in_o  (match_in_o),
  .done_o      (done_o)
);

// File: tb/mucf_matcher_bench.sv
`timescale 1ns/1ps
module mucf_matcher_bench;
  localparam int N  = 4;
  localparam int UW = 4;
  localparam int IW = 2;

  typedef struct packed {
    logic [15:0] pres;
    logic [63:0] urg;
    logic [3:0]  vld;
    logic [7:0]  min;
    logic [3:0]  lat;
  } vec_t;

  // urg: input i at bits [16i+15:16i], nibble o inside; min: output o at bits [2o+1:2o]
  localparam vec_t VECS [6] = '{
    '{16'h8421, 64'h1111_1111_1111_1111, 4'hF, 8'hE4, 4'd2},  // diagonal, all in round 1
    '{16'h0023, 64'h0000_0000_0030_0011, 4'h3, 8'h04, 4'd3},  // R5 tie -> output 0, R6 retry
    '{16'h0900, 64'h0000_2005_0000_0000, 4'h8, 8'h80, 4'd2},  // R5 urgency wins; R3 absent zeros
    '{16'h6002, 64'h0120_0000_0000_0070, 4'h6, 8'h30, 4'd3},  // R4 most urgent input, R6
    '{16'h0000, 64'h0000_0000_0000_0000, 4'h0, 8'h00, 4'd1},  // empty table
    '{16'h0051, 64'h0000_0000_000F_000F, 4'h5, 8'h10, 4'd2}   // R4 tie -> lower input
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*N-1:0]    pres = '0;
  logic [N*N*UW-1:0] urg = '0;
  logic [N-1:0]      m_vld;
  logic [N*IW-1:0]   m_in;
  logic              done;
  logic              phase;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mucf_matcher #(.N(N), .UW(UW)) u_mucf_matcher (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .present_i   (pres),
    .urgency_i   (urg),
    .match_vld_o (m_vld),
    .match_in_o  (m_in),
    .done_o      (done),
    .phase_o     (phase)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 vld", 64'(m_vld), 64'd0);
    chk("R1 in", 64'(m_in), 64'd0);
    chk("R1 phase", 64'(phase), 64'd0);

    for (int v = 0; v < 6; v++) begin
      pres  = VECS[v].pres;
      urg   = VECS[v].urg;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: scramble the table after capture
      pres = '1;
      urg  = '0;
      chk("R2 cleared", 64'({done, m_vld}), 64'd0);
      lat = 0;
      while (!done && lat < N + 2) begin
        @(negedge clk);
        lat++;
      end
      chk($sformatf("R8 latency v%0d", v), 64'(lat), 64'(VECS[v].lat));
      chk($sformatf("R6 R7 vld v%0d", v), 64'(m_vld), 64'(VECS[v].vld));
      chk($sformatf("R4 R5 R11 in v%0d", v), 64'(m_in), 64'(VECS[v].min));
      chk($sformatf("R10 phase v%0d", v), 64'(phase), 64'(v % 2));
    end

    // R9: results hold with no start
    repeat (3) @(negedge clk);
    chk("R9 done", 64'(done), 64'd1);
    chk("R9 vld", 64'(m_vld), 64'(VECS[5].vld));
    chk("R9 in", 64'(m_in), 64'(VECS[5].min));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule